// File: doc/BRIEF.md
# Synchronous Differential Clock Stop Controller

This block sits between a free-running reference clock and a bank of differential clock outputs, each a true/complement pair. An asynchronous active-low stop request parks every output that is marked stoppable at true-high/complement-low. Outputs that are not marked keep running. When the request is released, the parked outputs start again. Stopping and restarting happen only while the reference is high, so no output ever shows a shortened or lengthened pulse. A mask written through a simple register write port chooses the stoppable outputs, one bit per output. A per-output active-low enable forces a pair to low on both legs.

The request is first synchronized on falling edges of the reference, which are the rising edges of its complement. A four-state machine then moves through `ST_RUN` (all outputs running), `ST_ARM` (request seen; the mask is captured), `ST_PARK` (captured outputs held high) and `ST_RESUME` (a release was seen; outputs run again). The transitions are:
- RUN→ARM on a synchronized request.
- ARM→PARK if the request is still present.
- ARM→RUN if the request went away (abort).
- PARK→RESUME on release.
- RESUME→RUN unconditionally.

Top module: `diffclk_stop_ctrl`

## Requirements
- R1: After reset the mask holds all ones (every output stoppable), the machine is in ST_RUN, and each enabled true leg follows the reference while its complement leg is the inverse.
- R2: stop_req_n is active low and acts only after two successive falling edges of the reference have sampled it low. A low pulse that no falling edge samples has no effect on any output.
- R3: A parked output holds its true leg at 1 and its complement leg at 0 through both phases of the reference.
- R4: After stop_req_n falls, the true leg of each stoppable output shows no fewer than 2 and no more than 6 further low phases, then stays high.
- R5: After stop_req_n rises, a parked true leg is low again no later than the third falling edge of the reference.
- R6: Every low phase of a true leg lasts exactly half a reference period. Every high phase lasts an odd number of half periods.
- R7: Mask bit i set to 1 makes output i stoppable. An output whose bit is 0 keeps running during a stop.
- R8: The mask is captured at the RUN→ARM transition. A write that lands in that same cycle, or any later write during the stop, affects only the next stop request.
- R9: oe_n[i]=1 drives both legs of output i to 0 in every state.
- R10: For each enabled output, the complement leg is always the inverse of the true leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| cfg_we | input | 1 | Mask write strobe, sampled on rising clk_ref |
| cfg_wdata | input | N_OUT | Mask value; bit i = 1 makes output i stoppable |
| oe_n | input | N_OUT | Active-low output enables, one per pair |
| clk_out_t | output | N_OUT | True legs of the differential outputs |
| clk_out_c | output | N_OUT | Complement legs of the differential outputs |

## Verification
A mask write and the mask capture can fall on the same rising edge. The bench sets this up by lowering the request and timing a write so that it is captured at the edge where the machine enters ST_ARM. It then checks that the stop parks the outputs of the old mask and that the following stop parks those of the new one. Request release and a fresh request can also meet in ST_RESUME. Randomized request edges and hold times produce that case, and a pulse-width monitor on every true leg judges it by the rule that no runt or stretched pulse appears.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ARM    = 2'd1,
        ST_PARK   = 2'd2,
        ST_RESUME = 2'd3
    } stop_state_e;

endpackage

// File: rtl/csc_req_sync.sv
// Synchronizes the active-low stop request on falling reference edges
// (rising edges of the internal complement clock).
module csc_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req_n,
    output logic req
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] shift_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("csc_req_sync needs at least two stages");
        end
    endgenerate

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[LAST-1:0], ~stop_req_n};
        end
    end

    assign req = shift_q[LAST];

endmodule

// File: rtl/csc_fsm.sv
module csc_fsm
    import csc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    output stop_state_e state,
    output logic        park,
    output logic        snap_load
);
    stop_state_e state_q;
    stop_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        park      = 1'b0;
        snap_load = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (req) begin
                    state_d   = ST_ARM;
                    snap_load = 1'b1;
                end
            end
            ST_ARM: begin
                state_d = req ? ST_PARK : ST_RUN;
            end
            ST_PARK: begin
                park = 1'b1;
                if (!req) begin
                    state_d = ST_RESUME;
                end
            end
            ST_RESUME: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/csc_mask_regs.sv
// Software-written stoppable mask plus the copy frozen for one stop episode.
module csc_mask_regs #(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [N_OUT-1:0] cfg_wdata,
    input  logic             snap_load,
    output logic [N_OUT-1:0] mask_cfg,
    output logic [N_OUT-1:0] mask_snap
);
    localparam logic [N_OUT-1:0] MASK_RST = {N_OUT{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_cfg <= MASK_RST;
        end else if (cfg_we) begin
            mask_cfg <= cfg_wdata;
        end
    end

    // Captures the value held before any write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_snap <= MASK_RST;
        end else if (snap_load) begin
            mask_snap <= mask_cfg;
        end
    end

endmodule

// File: rtl/csc_out_gate.sv
// Per-pair gate. The park flag changes only on rising reference edges,
// i.e. inside the high phase, so OR-ing it in never cuts a pulse short.
module csc_out_gate #(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             park,
    input  logic [N_OUT-1:0] stop_sel,
    input  logic [N_OUT-1:0] oe_n,
    output logic [N_OUT-1:0] out_t,
    output logic [N_OUT-1:0] out_c
);
    genvar gi;
    generate
        for (gi = 0; gi < N_OUT; gi++) begin : g_pair
            logic level;
            assign level     = clk | (park & stop_sel[gi]);
            assign out_t[gi] = level & ~oe_n[gi];
            assign out_c[gi] = ~level & ~oe_n[gi];
        end
    endgenerate

endmodule

// File: rtl/diffclk_stop_ctrl.sv
module diffclk_stop_ctrl
    import csc_pkg::*;
#(
    parameter int N_OUT       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             stop_req_n,
    input  logic             cfg_we,
    input  logic [N_OUT-1:0] cfg_wdata,
    input  logic [N_OUT-1:0] oe_n,
    output logic [N_OUT-1:0] clk_out_t,
    output logic [N_OUT-1:0] clk_out_c
);
    logic             req_sync;
    stop_state_e      fsm_state;
    logic             park_en;
    logic             snap_load;
    logic [N_OUT-1:0] mask_cfg;
    logic [N_OUT-1:0] mask_snap;

    csc_req_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .stop_req_n(stop_req_n),
        .req       (req_sync)
    );

    csc_fsm u_fsm (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .req      (req_sync),
        .state    (fsm_state),
        .park     (park_en),
        .snap_load(snap_load)
    );

    csc_mask_regs #(
        .N_OUT(N_OUT)
    ) u_mask (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .snap_load(snap_load),
        .mask_cfg (mask_cfg),
        .mask_snap(mask_snap)
    );

    csc_out_gate #(
        .N_OUT(N_OUT)
    ) u_gate (
        .clk     (clk_ref),
        .park    (park_en),
        .stop_sel(mask_snap),
        .oe_n    (oe_n),
        .out_t   (clk_out_t),
        .out_c   (clk_out_c)
    );

endmodule

// File: rtl/csc_checker.sv
module csc_checker
    import csc_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_sync,
    input stop_state_e      fsm_state,
    input logic [N_OUT-1:0] mask_snap,
    input logic [N_OUT-1:0] oe_n,
    input logic [N_OUT-1:0] clk_out_t,
    input logic [N_OUT-1:0] clk_out_c
);
    localparam logic [N_OUT-1:0] ALL1 = {N_OUT{1'b1}};

    a_r2_idle_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RUN && !req_sync) |=> fsm_state == ST_RUN);

    a_r4_arm_resolves: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_ARM |=> (fsm_state == ST_PARK || fsm_state == ST_RUN));

    a_r5_release_leaves_park: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_PARK && !req_sync) |=> fsm_state == ST_RESUME);

    a_r5_resume_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_RESUME |=> fsm_state == ST_RUN);

    a_r3_parked_high: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_PARK |->
            (clk_out_t & mask_snap & ~oe_n) == (mask_snap & ~oe_n));

    a_r7_unmasked_run: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out_t & ~mask_snap & ~oe_n) == '0);

    a_r6_low_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state != ST_PARK |-> (clk_out_t & ~oe_n) == '0);

    a_r8_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_RUN && $past(fsm_state) != ST_RUN) |-> $stable(mask_snap));

    a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_out_t | clk_out_c) & oe_n) == '0);

    a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_out_t ^ clk_out_c) | oe_n) == ALL1);

endmodule

bind diffclk_stop_ctrl csc_checker #(
    .N_OUT(N_OUT)
) u_chk (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .req_sync (req_sync),
    .fsm_state(fsm_state),
    .mask_snap(mask_snap),
    .oe_n     (oe_n),
    .clk_out_t(clk_out_t),
    .clk_out_c(clk_out_c)
);

// File: tb/diffclk_stop_ctrl_tb.sv
`timescale 1ns/1ps
module diffclk_stop_ctrl_tb;
    localparam int PERIOD = 10;
    localparam int HALF   = PERIOD / 2;
    localparam int N      = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_req_n = 1'b1;
    logic         cfg_we = 1'b0;
    logic [N-1:0] cfg_wdata = '0;
    logic [N-1:0] oe_n = '0;
    logic [N-1:0] clk_out_t;
    logic [N-1:0] clk_out_c;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit mon_en  = 0;

    always #(HALF) clk = ~clk;

    diffclk_stop_ctrl #(.N_OUT(N), .SYNC_STAGES(2)) u_dut (
        .clk_ref   (clk),
        .rst_n     (rst_n),
        .stop_req_n(stop_req_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .oe_n      (oe_n),
        .clk_out_t (clk_out_t),
        .clk_out_c (clk_out_c)
    );

    // pulse-width monitor on all true legs (R6)
    logic [N-1:0] prev_t = '0;
    longint       last_edge [N] = '{default: -1};
    int           viol = 0;
    int           edges = 0;
    always @(clk_out_t) begin
        for (int i = 0; i < N; i++) begin
            if (clk_out_t[i] !== prev_t[i]) begin
                if (!mon_en) begin
                    last_edge[i] = -1;
                end else begin
                    if (last_edge[i] >= 0) begin
                        if (clk_out_t[i]) begin
                            if ($time - last_edge[i] != HALF) viol++;
                        end else begin
                            if (($time - last_edge[i]) % PERIOD != HALF) viol++;
                        end
                        edges++;
                    end
                    last_edge[i] = $time;
                end
            end
        end
        prev_t = clk_out_t;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    // samples one high phase and the following low phase
    task automatic check_phases(input logic [N-1:0] parked, input string tag);
        logic [N-1:0] en;
        en = ~oe_n;
        @(posedge clk); #3;
        chk(clk_out_t == en, {tag, " true leg high phase"}, clk_out_t, en);
        chk(clk_out_c == '0, {tag, " comp leg high phase"}, clk_out_c, 0);
        #5;
        chk(clk_out_t == (parked & en), {tag, " true leg low phase"}, clk_out_t, parked & en);
        chk(clk_out_c == (~parked & en), {tag, " comp leg low phase"}, clk_out_c, ~parked & en);
    endtask

    task automatic set_req(input logic lvl);
        @(posedge clk); #2;
        stop_req_n = lvl;
    endtask

    task automatic write_mask(input logic [N-1:0] m);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_wdata = m;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        check_phases('0, "R1 R10 reset running");
    endtask

    // R4 R3 R5 with the default all-ones mask
    task automatic t_entry_exit();
        int lows;
        int highs;
        set_req(1'b0);
        lows = 0;
        for (int k = 0; k < 10; k++) begin
            #6;
            if (clk_out_t[0] == 1'b0 && lows == k) lows++;
            #4;
        end
        chk(lows >= 2 && lows <= 6, "R4 entry low phases", lows, 3);
        check_phases('1, "R1 R3 R7 default mask parks all");
        check_phases('1, "R3 parked second cycle");
        set_req(1'b1);
        highs = 0;
        for (int k = 0; k < 4; k++) begin
            #6;
            if (clk_out_t[0] == 1'b1 && highs == k) highs++;
            #4;
        end
        chk(highs <= 2, "R5 release latency high phases", highs, 2);
        check_phases('0, "R5 running after release");
    endtask

    // R2: request pulse between falling edges is ignored
    task automatic t_glitch();
        @(posedge clk); #6;
        stop_req_n = 1'b0;
        #3;
        stop_req_n = 1'b1;
        for (int k = 0; k < 4; k++) check_phases('0, "R2 unsampled pulse no effect");
    endtask

    // R7: partial mask
    task automatic t_partial();
        write_mask(8'h0F);
        set_req(1'b0);
        repeat (6) @(posedge clk);
        check_phases(8'h0F, "R7 mask 0x0F parks low four");
        set_req(1'b1);
        repeat (4) @(posedge clk);
    endtask

    // R8: write coinciding with capture, then write during park
    task automatic t_capture();
        set_req(1'b0);                       // P0+2
        @(posedge clk); #2;                  // P1+2
        cfg_we = 1'b1; cfg_wdata = 8'hF0;    // captured at P2 with RUN->ARM
        @(posedge clk); #2;
        cfg_we = 1'b0;
        repeat (4) @(posedge clk);
        check_phases(8'h0F, "R8 same-cycle write uses old mask");
        write_mask(8'h3C);
        check_phases(8'h0F, "R8 write during park ignored");
        set_req(1'b1);
        repeat (4) @(posedge clk);
        set_req(1'b0);
        repeat (6) @(posedge clk);
        check_phases(8'h3C, "R8 new mask on next request");
        set_req(1'b1);
        repeat (4) @(posedge clk);
    endtask

    // R9: output enables
    task automatic t_oe();
        mon_en = 0;
        @(posedge clk); #2;
        oe_n = 8'hA5;
        check_phases('0, "R9 disabled pairs low, running");
        set_req(1'b0);
        repeat (6) @(posedge clk);
        check_phases(8'h3C, "R9 disabled pairs low while parked");
        set_req(1'b1);
        repeat (4) @(posedge clk);
        @(posedge clk); #2;
        oe_n = '0;
        repeat (3) @(posedge clk);
        mon_en = 1;
        check_phases('0, "R9 re-enabled pairs running");
    endtask

    // R6: randomized request timing, pulse widths judged by monitor
    task automatic t_random();
        int offs [8] = '{1, 2, 3, 4, 6, 7, 8, 9};
        void'($urandom(32'h5EED));
        for (int it = 0; it < 60; it++) begin
            @(posedge clk);
            #(offs[$urandom_range(7, 0)]);
            stop_req_n = ~stop_req_n;
            repeat ($urandom_range(8, 1)) @(posedge clk);
        end
        @(posedge clk); #2;
        stop_req_n = 1'b1;
        repeat (6) @(posedge clk);
        check_phases('0, "R5 running after random run");
        chk(viol == 0, "R6 no runt or stretched pulse", viol, 0);
        chk(edges > 500, "R6 monitor saw edges", edges, 500);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        mon_en = 1;
        t_reset();
        t_entry_exit();
        t_glitch();
        t_partial();
        t_capture();
        t_oe();
        t_random();
        summary();
        $finish;
    end

endmodule